// File: doc/BRIEF.md
# Triggered Pre/Post Sample Capture Controller

This block sits between a 20 MHz sample stream and a circular capture memory. Each incoming sample is a 12-bit signed converter code plus one gain-range bit, and both are stored together as one 13-bit word. A host arms the block with a pre-trigger length, a post-trigger length, a trigger level and a slope. From then on every valid sample is written at the next buffer address, and the address wraps around a power-of-two depth.

The trigger compares the range-normalized value (the code scaled by 16 when the range bit marks the attenuated path) against the level, never the raw code. A trigger is accepted only once enough samples have been written to fill the requested pre-trigger window. After the trigger, the block writes the programmed number of further samples and stops. It then raises a done flag. It reports the buffer address of the trigger sample and how many pre-trigger samples survive in the buffer, so a processor can read out the record. If the requested lengths do not fit in the buffer, they are clamped and an error flag is raised.

Top module: `trig_capture_ctrl`

## Requirements
- R1: After reset the block is idle: done and clamp_err are 0, and no sample is written even while smp_valid is high.
- R2: After an arm, each valid sample is written with mem_wdata bit 12 = smp_range and bits 11:0 = smp_code. The first write goes to address 0, and each later write goes to the previous address plus one, modulo 2^ADDR_W.
- R3: The trigger compares a signed normalized value against the level. The normalized value is the code when smp_range is 0, and the code times 16 when smp_range is 1.
- R4: When trig_falling is 0, a sample triggers when the previous normalized sample is below the level and this sample is at or above it.
- R5: When trig_falling is 1, a sample triggers when the previous normalized sample is above the level and this sample is at or below it.
- R6: A crossing is ignored unless at least the effective pre-trigger count of samples has been written since the arm, before the crossing sample. The first sample after an arm never triggers.
- R7: After the trigger sample, exactly the effective post-trigger count of further samples is written. done is 1 from the cycle after the last of these writes, and no sample is written while done is 1.
- R8: At done, trig_addr is the address of the trigger sample, and pre_valid is the lesser of the number of samples written before the trigger and 2^ADDR_W-1 minus the effective post count. Both hold until the next arm.
- R9: An arm in any state clears done and restarts capture at address 0. A sample presented in the arm cycle is not written.
- R10: The effective post count is min(post_len, 2^ADDR_W-1), and the effective pre count is min(pre_len, 2^ADDR_W-1 minus the effective post count). clamp_err is set at the arm when pre_len+post_len exceeds 2^ADDR_W-1, and it holds until the next arm.
- R11: pre_len, post_len, trig_level and trig_falling are sampled only in the arm cycle. Changing them afterwards has no effect on the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_code | input | 12 | Signed converter code |
| smp_range | input | 1 | 1 = attenuated range (x16 weight) |
| arm | input | 1 | Start a new capture |
| pre_len | input | ADDR_W+1 | Requested pre-trigger samples |
| post_len | input | ADDR_W+1 | Requested post-trigger samples |
| trig_level | input | 16 | Signed normalized trigger level |
| trig_falling | input | 1 | 0 = rising slope, 1 = falling slope |
| mem_we | output | 1 | Write strobe to the capture RAM |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | 13 | {range, code} word |
| done | output | 1 | Record complete |
| trig_addr | output | ADDR_W | Address of the trigger sample |
| pre_valid | output | ADDR_W+1 | Surviving pre-trigger samples |
| clamp_err | output | 1 | Requested lengths were clamped |

## Verification
The bench aims at crossings that arrive before the pre-trigger window is full. A design that accepts them reports a trigger address that is too early. It also covers level hits that occur only after normalization by the range bit, which a raw-code comparison would miss or misplace. Equality with the level on either slope is tested. Records longer than the buffer force wrap-around and clamping, where wrong arithmetic shows up as a bad pre_valid, a wrong write count or an overwritten trigger word. The last group of cases re-arms during an unfinished capture and changes the settings after arming. A design that keeps stale state or samples the settings late would write to the wrong addresses or miss the trigger.

// File: rtl/cap_pkg.sv
package cap_pkg;

  localparam int CODE_W      = 12;
  localparam int RANGE_SHIFT = 4;
  localparam int NORM_W      = CODE_W + RANGE_SHIFT;
  localparam int WORD_W      = CODE_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMING,
    ST_WAIT,
    ST_POST,
    ST_DONE
  } cap_state_e;

  // Scale an attenuated-range code so both ranges share one level scale.
  function automatic logic signed [NORM_W-1:0] norm_sample(
      input logic signed [CODE_W-1:0] code,
      input logic                     rng);
    logic signed [NORM_W-1:0] ext;
    ext = NORM_W'(code);
    return rng ? (ext <<< RANGE_SHIFT) : ext;
  endfunction

  function automatic logic level_cross(
      input logic signed [NORM_W-1:0] prev,
      input logic signed [NORM_W-1:0] cur,
      input logic signed [NORM_W-1:0] level,
      input logic                     falling);
    if (falling) return (prev > level) && (cur <= level);
    return (prev < level) && (cur >= level);
  endfunction

endpackage

// File: rtl/cap_len_clamp.sv
module cap_len_clamp #(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W:0] pre_req,
  input  logic [ADDR_W:0] post_req,
  output logic [ADDR_W:0] pre_eff,
  output logic [ADDR_W:0] post_eff,
  output logic            over
);
  // One slot is reserved for the trigger word itself.
  localparam logic [ADDR_W:0]   CAP_V   = (ADDR_W+1)'((1 << ADDR_W) - 1);
  localparam logic [ADDR_W+1:0] CAP_EXT = {1'b0, CAP_V};

  function automatic logic [ADDR_W:0] min_len(input logic [ADDR_W:0] a,
                                              input logic [ADDR_W:0] b);
    return (a < b) ? a : b;
  endfunction

  logic [ADDR_W+1:0] req_sum;

  always_comb begin
    req_sum  = {1'b0, pre_req} + {1'b0, post_req};
    post_eff = min_len(post_req, CAP_V);
    pre_eff  = min_len(pre_req, CAP_V - post_eff);
    over     = req_sum > CAP_EXT;
  end

endmodule

// File: rtl/cap_wr_ptr.sv
module cap_wr_ptr #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W:0]   fill
);
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(1 << ADDR_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      fill <= '0;
    end else if (clear) begin
      ptr  <= '0;
      fill <= '0;
    end else if (adv) begin
      ptr <= ptr + 1'b1;
      if (fill != DEPTH_V) fill <= fill + 1'b1;
    end
  end

endmodule

// File: rtl/cap_trig_det.sv
module cap_trig_det
  import cap_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     smp_en,
  input  logic signed [CODE_W-1:0] code,
  input  logic                     rng,
  input  logic signed [NORM_W-1:0] level,
  input  logic                     falling,
  output logic                     hit
);
  logic signed [NORM_W-1:0] cur_n;
  logic signed [NORM_W-1:0] prev_q;
  logic                     have_prev_q;

  assign cur_n = norm_sample(code, rng);
  assign hit   = smp_en && have_prev_q && level_cross(prev_q, cur_n, level, falling);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (clear) begin
      have_prev_q <= 1'b0;
    end else if (smp_en) begin
      prev_q      <= cur_n;
      have_prev_q <= 1'b1;
    end
  end

endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
  import cap_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  input  logic              smp_range,
  input  logic              arm,
  input  logic [ADDR_W:0]   pre_len,
  input  logic [ADDR_W:0]   post_len,
  input  logic [NORM_W-1:0] trig_level,
  input  logic              trig_falling,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              done,
  output logic [ADDR_W-1:0] trig_addr,
  output logic [ADDR_W:0]   pre_valid,
  output logic              clamp_err
);
  localparam logic [ADDR_W:0] CAP_V = (ADDR_W+1)'((1 << ADDR_W) - 1);

  // Pre-trigger words that can survive once the post window is written.
  function automatic logic [ADDR_W:0] survivors(input logic [ADDR_W:0] written,
                                                input logic [ADDR_W:0] post_n);
    logic [ADDR_W:0] room;
    room = CAP_V - post_n;
    return (written < room) ? written : room;
  endfunction

  cap_state_e               state_q;
  logic [ADDR_W:0]          pre_eff_q, post_eff_q, post_cnt_q;
  logic signed [NORM_W-1:0] level_q;
  logic                     falling_q;
  logic                     clamp_err_q;
  logic [ADDR_W-1:0]        trig_addr_q;
  logic [ADDR_W:0]          pre_valid_q;

  // Named internal events for the checker.
  logic                     capturing;
  logic                     accept;
  logic                     pre_met;
  logic                     det_hit;
  logic                     trig_hit;
  logic [ADDR_W-1:0]        wptr;
  logic [ADDR_W:0]          fill_cnt;
  logic [ADDR_W:0]          pre_eff_c, post_eff_c;
  logic                     over_c;

  cap_len_clamp #(.ADDR_W(ADDR_W)) u_clamp (
    .pre_req  (pre_len),
    .post_req (post_len),
    .pre_eff  (pre_eff_c),
    .post_eff (post_eff_c),
    .over     (over_c)
  );

  cap_wr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (arm),
    .adv   (accept),
    .ptr   (wptr),
    .fill  (fill_cnt)
  );

  cap_trig_det u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (arm),
    .smp_en  (accept),
    .code    ($signed(smp_code)),
    .rng     (smp_range),
    .level   (level_q),
    .falling (falling_q),
    .hit     (det_hit)
  );

  assign capturing = (state_q == ST_ARMING) || (state_q == ST_WAIT) || (state_q == ST_POST);
  assign accept    = smp_valid && capturing && !arm;
  assign pre_met   = fill_cnt >= pre_eff_q;
  assign trig_hit  = det_hit && pre_met &&
                     ((state_q == ST_ARMING) || (state_q == ST_WAIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pre_eff_q   <= '0;
      post_eff_q  <= '0;
      post_cnt_q  <= '0;
      level_q     <= '0;
      falling_q   <= 1'b0;
      clamp_err_q <= 1'b0;
      trig_addr_q <= '0;
      pre_valid_q <= '0;
    end else if (arm) begin
      state_q     <= ST_ARMING;
      pre_eff_q   <= pre_eff_c;
      post_eff_q  <= post_eff_c;
      post_cnt_q  <= '0;
      level_q     <= $signed(trig_level);
      falling_q   <= trig_falling;
      clamp_err_q <= over_c;
      trig_addr_q <= '0;
      pre_valid_q <= '0;
    end else if (trig_hit) begin
      trig_addr_q <= wptr;
      pre_valid_q <= survivors(fill_cnt, post_eff_q);
      post_cnt_q  <= '0;
      state_q     <= (post_eff_q == '0) ? ST_DONE : ST_POST;
    end else begin
      unique case (state_q)
        ST_ARMING: if (pre_met) state_q <= ST_WAIT;
        ST_POST: begin
          if (accept) begin
            post_cnt_q <= post_cnt_q + 1'b1;
            if (post_cnt_q + 1'b1 == post_eff_q) state_q <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign mem_we    = accept;
  assign mem_addr  = wptr;
  assign mem_wdata = {smp_range, smp_code};
  assign done      = (state_q == ST_DONE);
  assign trig_addr = trig_addr_q;
  assign pre_valid = pre_valid_q;
  assign clamp_err = clamp_err_q;

endmodule

// File: rtl/cap_ctrl_chk.sv
module cap_ctrl_chk
  import cap_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input cap_state_e        state_q,
  input logic              trig_hit,
  input logic [ADDR_W:0]   fill_cnt,
  input logic [ADDR_W:0]   pre_eff_q,
  input logic [ADDR_W:0]   post_eff_q,
  input logic              done,
  input logic [ADDR_W-1:0] trig_addr,
  input logic [ADDR_W:0]   pre_valid
);
  localparam logic [ADDR_W+1:0] CAP_EXT = (ADDR_W+2)'((1 << ADDR_W) - 1);

  a_r7_no_write_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) || (state_q == ST_DONE)) |-> !mem_we);

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  a_r6_trig_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> (fill_cnt >= pre_eff_q));

  a_r8_record_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> (done && $stable(trig_addr) && $stable(pre_valid)));

  a_r9_arm_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !done);

  a_r10_window_fits: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (({1'b0, pre_valid} + {1'b0, post_eff_q}) <= CAP_EXT));

endmodule

bind trig_capture_ctrl cap_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arm        (arm),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .state_q    (state_q),
  .trig_hit   (trig_hit),
  .fill_cnt   (fill_cnt),
  .pre_eff_q  (pre_eff_q),
  .post_eff_q (post_eff_q),
  .done       (done),
  .trig_addr  (trig_addr),
  .pre_valid  (pre_valid)
);

// File: tb/trig_capture_ctrl_tb.sv
`timescale 1ns/1ps
module trig_capture_ctrl_tb;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 5;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int ROOM   = DEPTH - 1;
  localparam int MAXN   = 320;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_valid = 1'b0;
  logic [11:0]       smp_code = '0;
  logic              smp_range = 1'b0;
  logic              arm = 1'b0;
  logic [ADDR_W:0]   pre_len = '0;
  logic [ADDR_W:0]   post_len = '0;
  logic [15:0]       trig_level = '0;
  logic              trig_falling = 1'b0;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [12:0]       mem_wdata;
  logic              done;
  logic [ADDR_W-1:0] trig_addr;
  logic [ADDR_W:0]   pre_valid;
  logic              clamp_err;

  trig_capture_ctrl #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
    .smp_range(smp_range), .arm(arm), .pre_len(pre_len), .post_len(post_len),
    .trig_level(trig_level), .trig_falling(trig_falling), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done),
    .trig_addr(trig_addr), .pre_valid(pre_valid), .clamp_err(clamp_err)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [11:0] sc [MAXN];
  logic        sr [MAXN];
  logic [12:0] bmem [DEPTH];
  int nwr, ncnt, done_at, addr_bad;
  bit scramble;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bench view of the level scale: attenuated samples weigh sixteen times more.
  function automatic int scaled(input logic [11:0] c, input logic r);
    int v;
    v = int'($signed(c));
    return r ? v * 16 : v;
  endfunction

  function automatic bit crossed(input int p, input int c, input int lvl, input bit fall);
    return fall ? (p > lvl && c <= lvl) : (p < lvl && c >= lvl);
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic drive(input bit v, input logic [11:0] c, input logic r);
    @(negedge clk);
    if (done && done_at < 0) done_at = ncnt;
    arm = 1'b0;
    if (scramble) begin
      pre_len      = ($urandom % 64);
      post_len     = ($urandom % 64);
      trig_level   = $urandom;
      trig_falling = $urandom;
    end
    smp_valid = v; smp_code = c; smp_range = r;
    #(CLK_P/2 - 1);
    if (mem_we) begin
      bmem[mem_addr] = mem_wdata;
      if (int'(mem_addr) != nwr % DEPTH) addr_bad++;
      nwr++;
    end
    if (v) ncnt++;
  endtask

  task automatic do_arm(input int pre, input int post, input int lvl, input bit fall);
    @(negedge clk);
    arm = 1'b1; pre_len = pre[ADDR_W:0]; post_len = post[ADDR_W:0];
    trig_level = lvl[15:0]; trig_falling = fall;
    smp_valid = 1'b1; smp_code = $urandom; smp_range = $urandom;
    #(CLK_P/2 - 1);
    chk("R9 write in arm cycle", int'(mem_we), 0);
  endtask

  task automatic run_case(input int pre, input int post, input int lvl, input bit fall,
                          input int n, input bit gaps, input bit scr);
    int pe_post, pe_pre, k, exp_wr, pv, bad;
    bit over, exp_done;
    pe_post = imin(post, ROOM);
    pe_pre  = imin(pre, ROOM - pe_post);
    over    = (pre + post) > ROOM;
    k = -1;
    for (int i = 1; i < n; i++)
      if (k < 0 && i >= pe_pre &&
          crossed(scaled(sc[i-1], sr[i-1]), scaled(sc[i], sr[i]), lvl, fall)) k = i;
    exp_done = (k >= 0) && (k + pe_post < n);
    exp_wr   = exp_done ? k + pe_post + 1 : n;
    for (int i = 0; i < DEPTH; i++) bmem[i] = 13'h0;
    do_arm(pre, post, lvl, fall);
    nwr = 0; ncnt = 0; done_at = -1; addr_bad = 0; scramble = scr;
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) drive(1'b0, 12'h0, 1'b0);
      drive(1'b1, sc[i], sr[i]);
    end
    drive(1'b0, 12'h0, 1'b0);
    drive(1'b0, 12'h0, 1'b0);
    scramble = 0;
    chk("R10 clamp_err", int'(clamp_err), int'(over));
    chk("R7 done", int'(done), int'(exp_done));
    chk("R7 write count", nwr, exp_wr);
    chk("R2 address order", addr_bad, 0);
    if (exp_done) begin
      pv = imin(k, ROOM - pe_post);
      chk("R7 done timing", done_at, k + pe_post + 1);
      chk("R8 trig_addr", int'(trig_addr), k % DEPTH);
      chk("R8 pre_valid", int'(pre_valid), pv);
      bad = 0;
      for (int j = 0; j <= pe_post; j++)
        if (bmem[(k + j) % DEPTH] != {sr[k+j], sc[k+j]}) bad++;
      for (int j = 1; j <= pv; j++)
        if (bmem[(k - j) % DEPTH] != {sr[k-j], sc[k-j]}) bad++;
      chk("R2 record words", bad, 0);
    end
  endtask

  task automatic set_s(input int i, input int code, input logic r);
    sc[i] = code[11:0]; sr[i] = r;
  endtask

  initial begin
    void'($urandom(32'd24681357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nwr = 0; ncnt = 0; done_at = -1; addr_bad = 0; scramble = 0;
    for (int i = 0; i < 5; i++) drive(1'b1, 12'h123, 1'b0);
    chk("R1 no write before arm", nwr, 0);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 clamp_err after reset", int'(clamp_err), 0);

    // R4: rising ramp, crossing at index 5 with pre 4 post 6.
    for (int i = 0; i < 30; i++) set_s(i, i * 20, 1'b0);
    run_case(4, 6, 100, 0, 30, 0, 0);
    // R4: equality with level counts, equality of the previous sample does not.
    set_s(0, 100, 0); set_s(1, 150, 0); set_s(2, 99, 0); set_s(3, 100, 0);
    for (int i = 4; i < 12; i++) set_s(i, 50, 0);
    run_case(0, 3, 100, 0, 12, 0, 0);
    // R6: early crossing at index 2 ignored with pre 8; real one at 12.
    for (int i = 0; i < 30; i++) set_s(i, 0, 1'b0);
    set_s(2, 200, 0); set_s(3, 200, 0); set_s(12, 200, 0); set_s(13, 200, 0);
    run_case(8, 4, 100, 0, 30, 1, 0);
    // R5: falling ramp and falling equality.
    for (int i = 0; i < 30; i++) set_s(i, 100 - 15 * i, 1'b0);
    run_case(3, 5, -50, 1, 30, 0, 0);
    set_s(0, 101, 0); set_s(1, 100, 0);
    for (int i = 2; i < 10; i++) set_s(i, 0, 0);
    run_case(1, 2, 100, 1, 10, 0, 0);
    // R3: full-scale raw code stays below 3000; range bit lifts 200 to 3200.
    for (int i = 0; i < 20; i++) set_s(i, 2047, 1'b0);
    set_s(8, 200, 1); set_s(9, 200, 1);
    run_case(2, 3, 3000, 0, 20, 0, 0);
    // R7: zero pre and zero post, trigger on the second sample.
    set_s(0, 0, 0);
    for (int i = 1; i < 8; i++) set_s(i, 500, 0);
    run_case(0, 0, 100, 0, 8, 0, 0);
    // R10: clamp both ways; long records wrap the buffer.
    for (int i = 0; i < 200; i++) set_s(i, (i == 60) ? 900 : 0, 1'b0);
    run_case(40, 20, 100, 0, 200, 1, 0);
    run_case(10, 50, 100, 0, 200, 0, 0);
    run_case(31, 0, 100, 0, 200, 0, 0);
    // R9: re-arm while still in the post window, then a fresh capture.
    for (int i = 0; i < 10; i++) set_s(i, (i >= 5) ? 300 : 0, 1'b0);
    run_case(2, 20, 100, 0, 10, 0, 0);
    run_case(2, 3, 100, 0, 10, 0, 0);
    // R11: settings changed after arm; random records with gaps.
    for (int t = 0; t < 40; t++) begin
      int n;
      n = 20 + int'($urandom % 280);
      for (int i = 0; i < n; i++) set_s(i, int'($urandom % 4096), ($urandom % 4) == 0);
      run_case(int'($urandom % 41), int'($urandom % 41),
               int'($urandom % 6001) - 3000, $urandom, n, 1, 1);
    end
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule